// File: doc/BRIEF.md
# Multiplexed Read Channel Sequencer

The sequencer paces an external analog multiplexer that takes turns over ten time slots: one auxiliary slot, eight data channel slots and one idle slot. It drives a slot clock at one eighth of the master clock, with a rise at every slot boundary. It also drives a frame sync line that is high across the rising edge that opens the auxiliary slot. On the digital side it reports the current slot number. For each used slot it raises one per-channel strobe on the master cycle just before the next slot-clock rise, gated by the ADC sample-valid input. A downstream demultiplexer uses that strobe to route the sample to its channel. A one-cycle frame-start pulse marks the first master cycle of each frame.

A 2-bit operating mode sets what the lines do. In normal and test mode both lines run. In search mode the sync line is held high, so every slot carries the auxiliary signal. In off mode both lines are held high and the counters wait at the end of the idle slot. As a result, the first running edge after off mode, or after reset, always opens the auxiliary slot.

Top module: `read_slot_sequencer`

## Requirements
- R1: While the mode is not off, the slot clock is high for the first 4 master cycles of every slot and low for the last 4, so it has a period of 8 master cycles and rises at each slot boundary.
- R2: The slot number counts 0 to 9 and advances by one every 8 master cycles, wrapping from 9 to 0. Slot 0 is the auxiliary slot, slots 1 to 8 carry data channels 0 to 7, and slot 9 is idle.
- R3: In normal (01) and test (10) mode the frame sync is high from the middle of slot 9 to the middle of slot 0, which is 8 master cycles. It is low at all other times.
- R4: In search mode (11) the frame sync stays high and the slot clock keeps running as in R1.
- R5: In off mode (00) the slot clock and frame sync are both high, the slot number reads 9, and no strobe and no frame start are issued.
- R6: Strobe bit 8 belongs to slot 0 and bit k-1 belongs to slot k (k = 1 to 8). A strobe is issued only on the 8th master cycle of its slot while the sample-valid input is high, so at most one bit is high at a time. Slot 9 gives no strobe.
- R7: In search mode only the auxiliary bit (bit 8) strobes, in slot 0 of each frame.
- R8: Frame start is high for exactly one master cycle, the first cycle of slot 0, and only while running. The first clock edge after leaving off mode opens slot 0.
- R9: A synchronous active-low reset parks the sequencer as in off mode. The first edge after reset is released, in a running mode, enters slot 0.
- R10: While sample-valid is low, no strobe bit is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 00 off, 01 normal, 10 test, 11 search |
| adc_valid | input | 1 | ADC sample-valid strobe |
| slot_clk | output | 1 | Slot clock to the multiplexer |
| frame_sync | output | 1 | Frame sync to the multiplexer |
| slot_idx | output | 4 | Current slot number |
| ch_strobe | output | 9 | Per-channel sample strobe, bit 8 auxiliary |
| frame_start | output | 1 | First master cycle of a frame |

## Verification
If the phase counter slips, the slot clock shows it at its next edge, within four master cycles. If the slot counter is wrong, the slot number output shows it on the next cycle. Within one slot the strobe also lands on the wrong channel bit, and the sync window moves away from the edge that opens slot 0. A fault in mode forcing shows on the first cycle after the mode changes, with off or search mode leaving a line low.

// File: rtl/rdseq_pkg.sv
// Shared types for the read slot sequencer.
package rdseq_pkg;
    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_NORMAL = 2'b01,
        MODE_TEST   = 2'b10,
        MODE_SEARCH = 2'b11
    } seq_mode_e;
endpackage

// File: rtl/rdseq_slot_timer.sv
// Phase and slot counters. Counts DIV master cycles per slot and SLOTS
// slots per frame. In off mode or in reset it parks at the last phase of
// the last (idle) slot, so the next running edge opens slot 0.
// Assumes DIV >= 2. Also exposes next-state values and a registered mode.
module rdseq_slot_timer
    import rdseq_pkg::*;
#(
    parameter int DIV   = 8,
    parameter int SLOTS = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  seq_mode_e                mode_i,
    output logic [$clog2(DIV)-1:0]   phase_o,
    output logic [$clog2(SLOTS)-1:0] slot_o,
    output logic [$clog2(DIV)-1:0]   phase_nx_o,
    output logic [$clog2(SLOTS)-1:0] slot_nx_o,
    output seq_mode_e                mode_q_o
);
    localparam int PH_W = $clog2(DIV);
    localparam int SL_W = $clog2(SLOTS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
    localparam logic [SL_W-1:0] SL_LAST = SL_W'(SLOTS - 1);

    // Next-state counter logic: park when off, else step phase then slot.
    always_comb begin
        if (mode_i == MODE_OFF) begin
            phase_nx_o = PH_LAST;
            slot_nx_o  = SL_LAST;
        end else if (phase_o == PH_LAST) begin
            phase_nx_o = '0;
            slot_nx_o  = (slot_o == SL_LAST) ? '0 : slot_o + 1'b1;
        end else begin
            phase_nx_o = phase_o + 1'b1;
            slot_nx_o  = slot_o;
        end
    end

    // Counter and mode registers with synchronous reset to the park point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o  <= PH_LAST;
            slot_o   <= SL_LAST;
            mode_q_o <= MODE_OFF;
        end else begin
            phase_o  <= phase_nx_o;
            slot_o   <= slot_nx_o;
            mode_q_o <= mode_i;
        end
    end

    // R2: the frame wraps from the idle slot into the auxiliary slot
    a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_OFF && phase_o == PH_LAST && slot_o == SL_LAST)
        |=> (slot_o == '0 && phase_o == '0));

    // R2: the slot holds until its last phase
    a_r2_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_OFF && phase_o != PH_LAST) |=> $stable(slot_o));

    // R5: off mode parks the counters at the end of the idle slot
    a_r5_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_OFF) |=> (phase_o == PH_LAST && slot_o == SL_LAST));
endmodule

// File: rtl/rdseq_line_driver.sv
// Registered slot clock, frame sync and frame-start outputs. Each output
// is decoded from the counters' next state, so the registered lines match
// the counters in the same cycle and cannot glitch. Mode forcing is applied here.
module rdseq_line_driver
    import rdseq_pkg::*;
#(
    parameter int DIV   = 8,
    parameter int SLOTS = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  seq_mode_e                mode_i,
    input  logic [$clog2(DIV)-1:0]   phase_nx_i,
    input  logic [$clog2(SLOTS)-1:0] slot_nx_i,
    output logic                     slot_clk_o,
    output logic                     frame_sync_o,
    output logic                     frame_start_o
);
    localparam int PH_W = $clog2(DIV);
    localparam int SL_W = $clog2(SLOTS);
    localparam logic [PH_W-1:0] HALF    = PH_W'(DIV / 2);
    localparam logic [SL_W-1:0] SL_LAST = SL_W'(SLOTS - 1);

    logic run, first_half, sync_win;
    logic clk_d, sync_d, fs_d;

    // Decode the line levels for the upcoming cycle.
    always_comb begin
        run        = (mode_i != MODE_OFF);
        first_half = (phase_nx_i < HALF);
        sync_win   = (slot_nx_i == '0 && first_half) ||
                     (slot_nx_i == SL_LAST && !first_half);
        clk_d      = !run || first_half;
        sync_d     = !run || (mode_i == MODE_SEARCH) || sync_win;
        fs_d       = run && (slot_nx_i == '0) && (phase_nx_i == '0);
    end

    // Output registers; reset matches off-mode forcing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_clk_o    <= 1'b1;
            frame_sync_o  <= 1'b1;
            frame_start_o <= 1'b0;
        end else begin
            slot_clk_o    <= clk_d;
            frame_sync_o  <= sync_d;
            frame_start_o <= fs_d;
        end
    end

    // R5: off mode forces both lines high and silences frame start
    a_r5_off_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_OFF) |=> (slot_clk_o && frame_sync_o && !frame_start_o));

    // R4: search mode holds the sync line high
    a_r4_search_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_SEARCH) |=> frame_sync_o);

    // R8: frame start lasts a single master cycle
    a_r8_fs_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |=> !frame_start_o);

    // R3: the frame opens with sync and slot clock both high
    a_r3_sync_at_open: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> (frame_sync_o && slot_clk_o));
endmodule

// File: rtl/rdseq_strobe_router.sv
// Per-channel sample strobes. A strobe fires on the last phase of a used
// slot while the ADC reports a valid sample. Slot 0 maps to the top bit
// (auxiliary), and slot k maps to bit k-1. Search mode keeps only the auxiliary bit.
// Assumes NCH <= SLOTS.
module rdseq_strobe_router
    import rdseq_pkg::*;
#(
    parameter int DIV   = 8,
    parameter int SLOTS = 10,
    parameter int NCH   = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  seq_mode_e                mode_q_i,
    input  logic                     valid_i,
    input  logic [$clog2(DIV)-1:0]   phase_i,
    input  logic [$clog2(SLOTS)-1:0] slot_i,
    output logic [NCH-1:0]           strobe_o
);
    localparam int PH_W = $clog2(DIV);
    localparam int SL_W = $clog2(SLOTS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
    localparam logic [SL_W-1:0] SL_LAST = SL_W'(SLOTS - 1);

    logic fire;

    // Sampling instant: the cycle before the next slot-clock rise.
    assign fire = valid_i && (mode_q_i != MODE_OFF) && (phase_i == PH_LAST);

    // One decoder per data channel.
    for (genvar g = 0; g < NCH - 1; g++) begin : g_data
        assign strobe_o[g] = fire && (mode_q_i != MODE_SEARCH) &&
                             (slot_i == SL_W'(g + 1));
    end

    // Auxiliary channel decoder.
    assign strobe_o[NCH-1] = fire && (slot_i == '0);

    // R6: never more than one channel strobed
    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe_o));

    // R6: strobes only at the last phase of a slot
    a_r6_last_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o != '0) |-> (phase_i == PH_LAST));

    // R6: the idle slot is never strobed
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_i == SL_LAST && SLOTS > NCH) |-> (strobe_o == '0));

    // R10: no sample-valid, no strobe
    a_r10_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> (strobe_o == '0));

    // R7: search mode strobes the auxiliary bit only
    a_r7_search_aux: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q_i == MODE_SEARCH) |-> (strobe_o[NCH-2:0] == '0));
endmodule

// File: rtl/read_slot_sequencer.sv
// Top level of the read slot sequencer. Paces an external ten-slot analog
// multiplexer and tells the demultiplexer where each ADC sample belongs.
// Assumes the mode input is synchronous to clk.
module read_slot_sequencer
    import rdseq_pkg::*;
#(
    parameter int DIV   = 8,
    parameter int SLOTS = 10,
    parameter int NCH   = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode,
    input  logic                     adc_valid,
    output logic                     slot_clk,
    output logic                     frame_sync,
    output logic [$clog2(SLOTS)-1:0] slot_idx,
    output logic [NCH-1:0]           ch_strobe,
    output logic                     frame_start
);
    localparam int PH_W = $clog2(DIV);
    localparam int SL_W = $clog2(SLOTS);

    seq_mode_e         mode_e, mode_q;
    logic [PH_W-1:0]   phase, phase_nx;
    logic [SL_W-1:0]   slot_nx;

    // Interpret the raw mode pins.
    assign mode_e = seq_mode_e'(mode);

    rdseq_slot_timer #(.DIV(DIV), .SLOTS(SLOTS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_e),
        .phase_o    (phase),
        .slot_o     (slot_idx),
        .phase_nx_o (phase_nx),
        .slot_nx_o  (slot_nx),
        .mode_q_o   (mode_q)
    );

    rdseq_line_driver #(.DIV(DIV), .SLOTS(SLOTS)) u_lines (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_e),
        .phase_nx_i    (phase_nx),
        .slot_nx_i     (slot_nx),
        .slot_clk_o    (slot_clk),
        .frame_sync_o  (frame_sync),
        .frame_start_o (frame_start)
    );

    rdseq_strobe_router #(.DIV(DIV), .SLOTS(SLOTS), .NCH(NCH)) u_router (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_q_i (mode_q),
        .valid_i  (adc_valid),
        .phase_i  (phase),
        .slot_i   (slot_idx),
        .strobe_o (ch_strobe)
    );
endmodule

// File: tb/read_slot_sequencer_tb.sv
module read_slot_sequencer_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       adc_valid = 1'b0;
    logic       slot_clk, frame_sync, frame_start;
    logic [3:0] slot_idx;
    logic [8:0] ch_strobe;

    int  nvec = 0;
    int  nfail = 0;
    bit  done = 0;
    int  mp = 7, ms = 9, me = 0;
    int  seg_stb = 0, seg_fs = 0;

    // Segments: {mode, valid, cycles, expected strobes, expected frame starts}
    localparam logic [16:0] VECS [0:6] = '{
        {2'd1, 1'b1, 8'd80, 4'd9, 2'd1},   // R6 normal, full frame
        {2'd2, 1'b1, 8'd80, 4'd9, 2'd1},   // R6 test mode, same timing
        {2'd3, 1'b1, 8'd80, 4'd1, 2'd1},   // R7 search, aux only
        {2'd1, 1'b0, 8'd80, 4'd0, 2'd1},   // R10 valid low
        {2'd0, 1'b1, 8'd16, 4'd0, 2'd0},   // R5 off
        {2'd1, 1'b1, 8'd40, 4'd5, 2'd1},   // R8 restart at slot 0
        {2'd3, 1'b1, 8'd40, 4'd0, 2'd0}    // R7 search, slots 5..9
    };

    read_slot_sequencer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .adc_valid   (adc_valid),
        .slot_clk    (slot_clk),
        .frame_sync  (frame_sync),
        .slot_idx    (slot_idx),
        .ch_strobe   (ch_strobe),
        .frame_start (frame_start)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (slot %0d phase %0d)",
                     tag, act, exp, ms, mp);
        end
    endtask

    // Drive one cycle, advance the reference model, compare off the edge.
    task automatic step(input logic [1:0] m, input logic v);
        int  e_clk, e_sync, e_fs, e_stb;
        bit  run;
        string t_clk, t_sync, t_stb;
        mode = m;
        adc_valid = v;
        @(posedge clk);
        if (!rst_n || m == 2'd0) begin
            mp = 7; ms = 9;
        end else if (mp == 7) begin
            mp = 0; ms = (ms == 9) ? 0 : ms + 1;
        end else begin
            mp++;
        end
        me = rst_n ? int'(m) : 0;
        @(negedge clk);
        run    = (me != 0);
        e_clk  = (!run || mp < 4) ? 1 : 0;
        e_sync = (!run || me == 3 || (ms == 0 && mp < 4) || (ms == 9 && mp >= 4)) ? 1 : 0;
        e_fs   = (run && ms == 0 && mp == 0) ? 1 : 0;
        e_stb  = 0;
        if (run && v && mp == 7) begin
            if (ms == 0) e_stb = 256;
            else if (ms <= 8 && me != 3) e_stb = 1 << (ms - 1);
        end
        t_clk  = (me == 3) ? "R4" : "R1";
        t_sync = (me == 3) ? "R4" : "R3";
        t_stb  = (me == 3) ? "R7" : (!v ? "R10" : "R6");
        if (!rst_n) begin
            t_clk = "R9"; t_sync = "R9"; t_stb = "R9";
        end else if (me == 0) begin
            t_clk = "R5"; t_sync = "R5"; t_stb = "R5";
        end
        chk(t_clk, int'(slot_clk), e_clk);
        chk(t_sync, int'(frame_sync), e_sync);
        chk("R8", int'(frame_start), e_fs);
        chk("R2", int'(slot_idx), ms);
        chk(t_stb, int'(ch_strobe), e_stb);
        if (ch_strobe != 9'd0) seg_stb++;
        if (frame_start) seg_fs++;
    endtask

    initial begin
        // Reset state: parked, lines high, nothing strobed (R9)
        rst_n = 1'b0;
        step(2'd1, 1'b1);
        step(2'd1, 1'b1);
        chk("R9", int'(slot_idx), 9);
        chk("R9", int'({slot_clk, frame_sync}), 3);
        chk("R9", int'(ch_strobe), 0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < 7; i++) begin
            logic [1:0] vm;
            logic       vv;
            int         nc, es, ef;
            string      tg;
            vm = VECS[i][16:15];
            vv = VECS[i][14];
            nc = int'(VECS[i][13:6]);
            es = int'(VECS[i][5:2]);
            ef = int'(VECS[i][1:0]);
            seg_stb = 0;
            seg_fs  = 0;
            for (int c = 0; c < nc; c++) step(vm, vv);
            tg = (vm == 2'd3) ? "R7" : (!vv ? "R10" : (vm == 2'd0 ? "R5" : "R6"));
            chk(tg, seg_stb, es);
            chk("R8", seg_fs, ef);
        end

        // Mid-run synchronous reset parks the sequencer (R9)
        for (int c = 0; c < 30; c++) step(2'd1, 1'b1);
        rst_n = 1'b0;
        step(2'd1, 1'b1);
        chk("R9", int'(slot_idx), 9);
        chk("R9", int'(frame_sync), 1);
        rst_n = 1'b1;
        step(2'd1, 1'b0);
        chk("R9", int'(slot_idx), 0);
        chk("R9", int'(frame_start), 1);

        // Off mode entered mid-frame forces lines at once (R5)
        for (int c = 0; c < 13; c++) step(2'd2, 1'b1);
        step(2'd0, 1'b1);
        chk("R5", int'({slot_clk, frame_sync}), 3);
        chk("R5", int'(slot_idx), 9);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R2: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule